// File: doc/BRIEF.md
# Big-Endian Subword Bus Data Aligner

This block sits between a CPU's load/store path and a 32-bit system bus. It accepts one request at a time. Each request has an address, an access size of 8, 16, 32 or 64 bits, a direction and, for stores, a 64-bit register value. The block turns the request into one or two bus beats. Every beat carries the full request address (plus four on the second beat of a 64-bit access), the size and the direction. Each beat completes when the bus raises `bus_ready` while `bus_valid` is high.

On stores, the register is shifted left so that its low byte or halfword lands in the big-endian byte lane that the address offset selects. The bits that are shifted along with it are not masked, so they appear in the other lanes. The receiving device must use the address offset to pick its lane. On loads, the bus returns the whole aligned 32-bit word, and the block extracts the addressed byte or halfword and extends it to 64 bits, with sign or zero extension as requested. A 64-bit load concatenates two returned words. A request whose address is not aligned to its size starts no bus activity and raises an address-exception pulse instead. Every other request ends with a single `done` pulse that carries the load result.

Top module: `bus_lane_aligner`

## Requirements
- R1: After reset, `bus_valid`, `done` and `addr_exc` are low and `req_ready` is high.
- R2: A request is misaligned when it is a halfword (size 1) with address bit 0 set, a word (size 2) with address bits 1:0 not zero, or a doubleword (size 3) with address bits 2:0 not zero. A misaligned request raises `addr_exc` for exactly the one cycle after it is accepted. It drives no `bus_valid` and no `done`.
- R3: `bus_valid` rises in the cycle after an aligned request is accepted. It carries the request address, the size and the direction. It stays high with a stable address and stable data until `bus_ready` is seen.
- R4: A byte store (size 0) drives `bus_wdata` = register bits 31:0 shifted left by 8×(3−offset), where offset is address bits 1:0. Register bits that are not part of the stored byte are not masked. For example, 0x12345678 at offset 1 gives 0x56780000.
- R5: A halfword store drives `bus_wdata` = register bits 31:0 shifted left by 8×(2−offset).
- R6: A word store drives register bits 31:0 unshifted. A doubleword store drives register bits 63:32 in the first beat at the request address, then register bits 31:0 in the second beat at the request address plus 4.
- R7: Byte lanes are big-endian. A byte load at offset k returns bus word bits [31−8k : 24−8k]. A halfword load at offset k returns bits [31−8k : 16−8k].
- R8: When `req_signed` is high, byte, halfword and word load results are sign-extended to 64 bits. When it is low, they are zero-extended.
- R9: A doubleword load returns {first beat word, second beat word}.
- R10: `done` is a one-cycle pulse. It rises in the cycle after the final beat's handshake, with `done_rdata` holding the load result, or zero for stores. `req_ready` is high only while no bus beat is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_signed | input | 1 | Sign-extend the load result |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Register value to store |
| bus_valid | output | 1 | Bus beat pending |
| bus_ready | input | 1 | Bus completes the beat |
| bus_write | output | 1 | Beat direction |
| bus_size | output | 2 | Access size of the beat |
| bus_addr | output | ADDR_W | Beat address |
| bus_wdata | output | 32 | Lane-positioned store word |
| bus_rdata | input | 32 | Aligned word returned on loads |
| done | output | 1 | Transaction complete pulse |
| done_rdata | output | 64 | Extended load result |
| addr_exc | output | 1 | Misaligned-address pulse |

## Verification
Two things can share a cycle. One is the `done` pulse of a finished transfer. The other is the acceptance of the next request, which can happen because `req_ready` is already high while `done` is shown. The bench provokes this by presenting a misaligned request in the very cycle that `done` is high. It then presents an aligned store in the cycle that `addr_exc` is high. It checks that the load result is intact, that the exception pulse follows exactly one cycle later with no bus beat, and that the store proceeds with correctly positioned lanes.

// File: rtl/aligner_pkg.sv
package aligner_pkg;
    localparam int WORD_W  = 32;
    localparam int REG_W   = 64;
    localparam int LANE_W  = 8;
    localparam int LANES   = WORD_W / LANE_W;
    localparam int OFF_W   = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } state_e;
endpackage

// File: rtl/align_check.sv
module align_check
    import aligner_pkg::*;
(
    input  size_e      size,
    input  logic [2:0] addr_lo,
    output logic       misaligned
);
    always_comb begin
        unique case (size)
            SZ_BYTE:  misaligned = 1'b0;
            SZ_HALF:  misaligned = addr_lo[0];
            SZ_WORD:  misaligned = |addr_lo[1:0];
            default:  misaligned = |addr_lo;
        endcase
    end
endmodule

// File: rtl/store_lane_shifter.sv
module store_lane_shifter
    import aligner_pkg::*;
(
    input  size_e               size,
    input  logic [OFF_W-1:0]    offset,
    input  logic [REG_W-1:0]    reg_val,
    output logic [WORD_W-1:0]   bus_word
);
    logic [OFF_W-1:0] byte_shift;
    logic [OFF_W-1:0] half_shift;

    always_comb begin
        byte_shift = OFF_W'(LANES - 1) - offset;
        half_shift = OFF_W'(LANES - 2) - offset;
        unique case (size)
            SZ_BYTE:  bus_word = reg_val[WORD_W-1:0] << {byte_shift, 3'b000};
            SZ_HALF:  bus_word = reg_val[WORD_W-1:0] << {half_shift, 3'b000};
            SZ_WORD:  bus_word = reg_val[WORD_W-1:0];
            default:  bus_word = reg_val[REG_W-1:WORD_W];
        endcase
    end
endmodule

// File: rtl/load_field_extractor.sv
module load_field_extractor
    import aligner_pkg::*;
(
    input  size_e               size,
    input  logic [OFF_W-1:0]    offset,
    input  logic                sign_ext,
    input  logic [WORD_W-1:0]   hi_word,
    input  logic [WORD_W-1:0]   lo_word,
    output logic [REG_W-1:0]    result
);
    logic [WORD_W-1:0] shifted;
    logic [7:0]        field8;
    logic [15:0]       field16;

    always_comb begin
        shifted = '0;
        field8  = '0;
        field16 = '0;
        unique case (size)
            SZ_BYTE: begin
                shifted = lo_word >> {OFF_W'(LANES - 1) - offset, 3'b000};
                field8  = shifted[7:0];
                result  = {{(REG_W-8){sign_ext & field8[7]}}, field8};
            end
            SZ_HALF: begin
                shifted = lo_word >> {OFF_W'(LANES - 2) - offset, 3'b000};
                field16 = shifted[15:0];
                result  = {{(REG_W-16){sign_ext & field16[15]}}, field16};
            end
            SZ_WORD:  result = {{(REG_W-WORD_W){sign_ext & lo_word[WORD_W-1]}}, lo_word};
            default:  result = {hi_word, lo_word};
        endcase
    end
endmodule

// File: rtl/bus_lane_aligner.sv
module bus_lane_aligner
    import aligner_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic                req_signed,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [REG_W-1:0]    req_wdata,
    output logic                bus_valid,
    input  logic                bus_ready,
    output logic                bus_write,
    output logic [1:0]          bus_size,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [WORD_W-1:0]   bus_wdata,
    input  logic [WORD_W-1:0]   bus_rdata,
    output logic                done,
    output logic [REG_W-1:0]    done_rdata,
    output logic                addr_exc
);
    localparam logic [ADDR_W-1:0] BEAT_STEP = ADDR_W'(WORD_W / LANE_W);

    typedef struct packed {
        state_e              st;
        logic                second;
        logic [ADDR_W-1:0]   addr;
        logic                write;
        size_e               size;
        logic                sgn;
        logic [WORD_W-1:0]   wdata;
        logic [WORD_W-1:0]   tail_wdata;
        logic [WORD_W-1:0]   first_rd;
        logic                done;
        logic [REG_W-1:0]    rdata;
        logic                exc;
    } state_t;

    state_t q, d;

    size_e              in_size;
    logic               in_misaligned;
    logic [WORD_W-1:0]  first_word;
    logic [REG_W-1:0]   load_result;

    assign in_size = size_e'(req_size);

    align_check u_align (
        .size       (in_size),
        .addr_lo    (req_addr[2:0]),
        .misaligned (in_misaligned)
    );

    store_lane_shifter u_shift (
        .size     (in_size),
        .offset   (req_addr[OFF_W-1:0]),
        .reg_val  (req_wdata),
        .bus_word (first_word)
    );

    load_field_extractor u_extract (
        .size     (q.size),
        .offset   (q.addr[OFF_W-1:0]),
        .sign_ext (q.sgn),
        .hi_word  (q.first_rd),
        .lo_word  (bus_rdata),
        .result   (load_result)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.exc  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (in_misaligned) begin
                        d.exc = 1'b1;
                    end else begin
                        d.st         = ST_BUSY;
                        d.second     = 1'b0;
                        d.addr       = req_addr;
                        d.write      = req_write;
                        d.size       = in_size;
                        d.sgn        = req_signed;
                        d.wdata      = first_word;
                        d.tail_wdata = req_wdata[WORD_W-1:0];
                    end
                end
            end
            default: begin
                if (bus_ready) begin
                    if (q.size == SZ_DWORD && !q.second) begin
                        d.second   = 1'b1;
                        d.addr     = q.addr + BEAT_STEP;
                        d.wdata    = q.tail_wdata;
                        d.first_rd = bus_rdata;
                    end else begin
                        d.st    = ST_IDLE;
                        d.done  = 1'b1;
                        d.rdata = q.write ? '0 : load_result;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign bus_valid  = (q.st == ST_BUSY);
    assign bus_write  = q.write;
    assign bus_size   = q.size;
    assign bus_addr   = q.addr;
    assign bus_wdata  = q.wdata;
    assign done       = q.done;
    assign done_rdata = q.rdata;
    assign addr_exc   = q.exc;
endmodule

// File: rtl/aligner_props.sv
module aligner_props #(
    parameter int ADDR_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                bus_valid,
    input logic                bus_ready,
    input logic [1:0]          bus_size,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_wdata,
    input logic                done,
    input logic                addr_exc
);
    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_wdata)); // R3
    AST_EXC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        addr_exc |-> !bus_valid && !done); // R2
    AST_EXC_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        addr_exc |-> $past(req_valid && req_ready)); // R2
    AST_HALF_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_size == 2'd1 |-> !bus_addr[0]); // R2
    AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_valid && bus_ready)); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_valid); // R10
endmodule

bind bus_lane_aligner aligner_props #(.ADDR_W(ADDR_W)) u_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .done      (done),
    .addr_exc  (addr_exc)
);

// File: tb/test_bus_lane_aligner.sv
module test_bus_lane_aligner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_signed = 1'b0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        bus_valid;
    logic        bus_ready = 1'b0;
    logic        bus_write;
    logic [1:0]  bus_size;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        done;
    logic [63:0] done_rdata;
    logic        addr_exc;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    bus_lane_aligner #(.ADDR_W(32)) i_bus_lane_aligner (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_signed(req_signed),
        .req_addr(req_addr), .req_wdata(req_wdata), .bus_valid(bus_valid),
        .bus_ready(bus_ready), .bus_write(bus_write), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done(done), .done_rdata(done_rdata), .addr_exc(addr_exc)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_load(input logic [1:0] sz, input logic sgn,
                                             input logic [1:0] off,
                                             input logic [31:0] w0, input logic [31:0] w1);
        logic [7:0]  b;
        logic [15:0] h;
        case (sz)
            2'd0: begin b = w0[8*(3-off) +: 8];  return {{56{sgn & b[7]}}, b}; end
            2'd1: begin h = w0[8*(2-off) +: 16]; return {{48{sgn & h[15]}}, h}; end
            2'd2: return {{32{sgn & w0[31]}}, w0};
            default: return {w0, w1};
        endcase
    endfunction

    task automatic issue(input logic wr, input logic [1:0] sz, input logic sgn,
                         input logic [31:0] addr, input logic [63:0] wd);
        req_write = wr; req_size = sz; req_signed = sgn; req_addr = addr; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic beat(input logic [31:0] exp_addr, input logic chk_wd, input logic [31:0] exp_wd,
                        input logic [31:0] rd, input int stall, input string tag);
        chk(bus_valid, 1, "R3 bus_valid");
        chk(bus_addr, exp_addr, "R3 bus_addr");
        if (chk_wd) chk(bus_wdata, exp_wd, tag);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk({bus_valid, bus_addr, bus_wdata}, {1'b1, exp_addr, chk_wd ? exp_wd : bus_wdata},
                "R3 held during stall");
        end
        bus_ready = 1'b1; bus_rdata = rd;
        @(negedge clk);
        bus_ready = 1'b0; bus_rdata = '0;
    endtask

    task automatic finish_txn(input logic [63:0] exp, input string tag);
        chk(done, 1, "R10 done pulse");
        chk(done_rdata, exp, tag);
        chk(req_ready, 1, "R10 ready when idle");
        @(negedge clk);
        chk(done, 0, "R10 done single cycle");
    endtask

    task automatic test_reset();
        chk({bus_valid, done, addr_exc, req_ready}, 4'b0001, "R1 reset state");
    endtask

    task automatic test_store_byte();
        for (int off = 0; off < 4; off++) begin
            issue(1, 2'd0, 0, 32'h40 + off, 64'hAAAA_BBBB_1234_5678);
            chk({bus_write, bus_size}, 3'b100, "R3 write/size");
            beat(32'h40 + off, 1, 32'h1234_5678 << (8 * (3 - off)), 0, 0, "R4 byte lanes unmasked");
            finish_txn(0, "R10 store rdata zero");
        end
    endtask

    task automatic test_store_half();
        for (int off = 0; off < 4; off += 2) begin
            issue(1, 2'd1, 0, 32'h80 + off, 64'h1234_5678);
            beat(32'h80 + off, 1, 32'h1234_5678 << (8 * (2 - off)), 0, 1, "R5 half lanes");
            finish_txn(0, "R10 store rdata zero");
        end
    endtask

    task automatic test_store_word_dword();
        issue(1, 2'd2, 0, 32'hC4, 64'hFFFF_0000_CAFE_F00D);
        beat(32'hC4, 1, 32'hCAFE_F00D, 0, 3, "R6 word unshifted");
        finish_txn(0, "R10 store rdata zero");
        issue(1, 2'd3, 0, 32'h100, 64'h1122_3344_5566_7788);
        beat(32'h100, 1, 32'h1122_3344, 0, 2, "R6 dword first beat high");
        beat(32'h104, 1, 32'h5566_7788, 0, 0, "R6 dword second beat low");
        finish_txn(0, "R10 store rdata zero");
    endtask

    task automatic test_load_sub();
        logic [31:0] w;
        w = 32'h80FF_7F01;
        for (int s = 0; s < 2; s++) begin
            for (int off = 0; off < 4; off++) begin
                issue(0, 2'd0, s[0], 32'h200 + off, 0);
                beat(32'h200 + off, 0, 0, w, 0, "");
                finish_txn(exp_load(2'd0, s[0], off[1:0], w, 0), "R7 R8 byte load");
            end
        end
        w = 32'h8001_7FFE;
        for (int s = 0; s < 2; s++) begin
            for (int off = 0; off < 4; off += 2) begin
                issue(0, 2'd1, s[0], 32'h300 + off, 0);
                beat(32'h300 + off, 0, 0, w, 1, "");
                finish_txn(exp_load(2'd1, s[0], off[1:0], w, 0), "R7 R8 half load");
            end
        end
    endtask

    task automatic test_load_word_dword();
        issue(0, 2'd2, 1, 32'h400, 0);
        beat(32'h400, 0, 0, 32'h8000_0000, 0, "");
        finish_txn(64'hFFFF_FFFF_8000_0000, "R8 signed word");
        issue(0, 2'd2, 0, 32'h400, 0);
        beat(32'h400, 0, 0, 32'h8000_0000, 0, "");
        finish_txn(64'h0000_0000_8000_0000, "R8 unsigned word");
        issue(0, 2'd3, 1, 32'h508, 0);
        beat(32'h508, 0, 0, 32'hDEAD_BEEF, 1, "");
        chk(done, 0, "R10 no done between beats");
        beat(32'h50C, 0, 0, 32'h0123_4567, 0, "");
        finish_txn(64'hDEAD_BEEF_0123_4567, "R9 dword load");
    endtask

    task automatic test_misaligned();
        logic [1:0]  sz [4] = '{2'd1, 2'd2, 2'd3, 2'd3};
        logic [31:0] ad [4] = '{32'h11, 32'h22, 32'h34, 32'h43};
        for (int i = 0; i < 4; i++) begin
            issue(i[0], sz[i], 0, ad[i], 64'h55);
            chk({addr_exc, bus_valid, done}, 3'b100, "R2 exception pulse");
            @(negedge clk);
            chk({addr_exc, bus_valid, done, req_ready}, 4'b0001, "R2 exception ends");
        end
    endtask

    task automatic test_overlap();
        issue(0, 2'd0, 1, 32'h602, 0);
        beat(32'h602, 0, 0, 32'hAABB_CCDD, 0, "");
        chk(done, 1, "R10 done");
        chk(done_rdata, 64'hFFFF_FFFF_FFFF_FFCC, "R7 R8 result with new request");
        chk(req_ready, 1, "R10 ready with done");
        issue(1, 2'd2, 0, 32'h606, 64'h77);
        chk({addr_exc, bus_valid, done}, 3'b100, "R2 exception after done");
        chk(req_ready, 1, "R10 ready during exception");
        issue(1, 2'd1, 0, 32'h20, 64'h1234_ABCD);
        chk(addr_exc, 0, "R2 exception cleared");
        beat(32'h20, 1, 32'hABCD_0000, 0, 0, "R5 store after exception");
        finish_txn(0, "R10 store rdata zero");
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_store_byte();
        test_store_half();
        test_store_word_dword();
        test_load_sub();
        test_load_word_dword();
        test_misaligned();
        test_overlap();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule